// File: doc/BRIEF.md
# Pause-Interval Frame Decoder

This block sits on the card side of a short-range link in which the reader marks every bit with a short carrier pause. Each pause ends with a rising edge on the demodulated level. The block times the gap between one rising edge and the next in clock cycles, and sorts each gap into one of three classes: a long gap (a one), a short gap (a zero) or an out-of-window gap (invalid). Valid bits are collected into a frame word. The frame is handed on when an invalid gap arrives or when the line stays quiet past the longest legal bit.

No length field is carried on the line. The bit count of each finished frame is reported alongside the word, so the logic downstream can tell command types apart by length: 6, 7, 11 and 23 bits are the sizes it expects. Interpreting commands, descrambling and replying are left to other blocks.

Top module: `pause_frame_decoder`

## Requirements
- R1: The interval is the number of clock cycles between two detected rising edges of `level_in`. The interval counter restarts on every rising edge, so one cycle after a rise the counter holds 1.
- R2: An interval strictly greater than 130 and strictly less than 170 cycles decodes as a 1 bit. The boundary values 131 and 169 are inside the window.
- R3: An interval strictly greater than 70 and strictly less than 110 cycles decodes as a 0 bit. The boundary values 71 and 109 are inside the window.
- R4: While a frame is open, any interval outside both windows closes the frame at that edge, and the bits gathered so far are reported. `frame_valid` rises 3 cycles after the level rise is applied (two synchroniser stages plus the edge register).
- R5: While no frame is open, an out-of-window interval produces no output. The first in-window interval opens a frame.
- R6: An open frame is closed when 170 cycles pass after its last detected rise. `frame_valid` is then seen 173 cycles after the level rise was applied.
- R7: Bits are stored least significant first: the first decoded bit goes to `frame_data[0]`. `frame_len` equals the number of bits decoded.
- R8: At most 31 bits are stored. Further valid bits keep the frame open but are dropped, and `frame_len` stays at 31.
- R9: `frame_valid` is high for exactly one cycle. `frame_data` and `frame_len` hold their values until the next frame. Each frame starts again from zero bits.
- R10: The interval counter stops at 3000 cycles (20 times the one-bit interval) and does not wrap. A gap of 4246 cycles is therefore invalid and does not alias to 150.
- R11: After reset, `frame_valid`, `frame_data` and `frame_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst | input | 1 | Synchronous active-high reset |
| level_in | input | 1 | Demodulated carrier level, asynchronous |
| frame_valid | output | 1 | One-cycle strobe: a frame has finished |
| frame_data | output | 31 | Decoded bits, first bit in bit 0, held between frames |
| frame_len | output | 5 | Number of bits in the reported frame |

## Verification
A wrong interval count or a wrong window edge shows up at the next strobe. The frame word gains, loses or flips a bit, and this appears at most 173 cycles after the last edge of the frame. An open flag left stuck high or stuck low shows as a missing strobe, an extra strobe, or a length that carries bits over from the previous frame. The strobe's cycle offset from the final edge tells a late timeout apart from an early invalid close. A counter that wraps instead of saturating is caught by the 4246-cycle gap, which would add a phantom bit.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_BAD  = 2'd2
  } sym_t;

  // Window test, exclusive at both ends around each nominal interval
  function automatic sym_t classify(input int ivl, input int one_t,
                                    input int zero_t, input int fuzz);
    if (ivl > one_t - fuzz && ivl < one_t + fuzz)
      return SYM_ONE;
    else if (ivl > zero_t - fuzz && ivl < zero_t + fuzz)
      return SYM_ZERO;
    else
      return SYM_BAD;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic s_meta, s_sync, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= level_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign rise = s_sync & ~s_prev;
endmodule

// File: rtl/pfd_interval_timer.sv
module pfd_interval_timer #(
  parameter int CNT_W      = 12,
  parameter int STOP_TICKS = 3000,
  parameter int TIMEOUT    = 170
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CNT_W'(STOP_TICKS);
    else if (rise)
      cnt <= CNT_W'(1);
    else if (cnt != CNT_W'(STOP_TICKS))
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= CNT_W'(TIMEOUT));
endmodule

// File: rtl/pfd_frame_assembler.sv
module pfd_frame_assembler #(
  parameter int MAX_BITS = 31,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  pfd_pkg::sym_t       sym,
  input  logic                expired,
  output logic                active,
  output logic                frame_valid,
  output logic [MAX_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]    frame_len
);
  import pfd_pkg::*;

  logic [MAX_BITS-1:0] acc;
  logic [LEN_W-1:0]    nbits;
  logic                end_frame, take_bit;

  always_comb begin
    take_bit  = rise && (sym != SYM_BAD);
    end_frame = active && (rise ? (sym == SYM_BAD) : expired);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      nbits       <= '0;
      active      <= 1'b0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      frame_len   <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (end_frame) begin
        frame_valid <= 1'b1;
        frame_data  <= acc;
        frame_len   <= nbits;
        acc         <= '0;
        nbits       <= '0;
        active      <= 1'b0;
      end else if (take_bit) begin
        active <= 1'b1;
        if (nbits < LEN_W'(MAX_BITS)) begin
          acc[nbits] <= (sym == SYM_ONE);
          nbits      <= nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pause_frame_decoder.sv
module pause_frame_decoder #(
  parameter int ONE_TICKS  = 150,
  parameter int ZERO_TICKS = 90,
  parameter int FUZZ_TICKS = 20,
  parameter int STOP_MULT  = 20,
  parameter int MAX_BITS   = 31,
  localparam int STOP_TICKS = ONE_TICKS * STOP_MULT,
  localparam int TIMEOUT    = ONE_TICKS + FUZZ_TICKS,
  localparam int CNT_W      = $clog2(STOP_TICKS + 1),
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                level_in,
  output logic                frame_valid,
  output logic [MAX_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]    frame_len
);
  import pfd_pkg::*;

  logic             rise;
  logic [CNT_W-1:0] iv_cnt;
  logic             expired;
  logic             active;
  sym_t             sym;

  pfd_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .level_in (level_in),
    .rise     (rise)
  );

  pfd_interval_timer #(
    .CNT_W      (CNT_W),
    .STOP_TICKS (STOP_TICKS),
    .TIMEOUT    (TIMEOUT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .cnt     (iv_cnt),
    .expired (expired)
  );

  assign sym = classify(int'(iv_cnt), ONE_TICKS, ZERO_TICKS, FUZZ_TICKS);

  pfd_frame_assembler #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) u_asm (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .sym         (sym),
    .expired     (expired),
    .active      (active),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_len   (frame_len)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int CNT_W      = 12,
  parameter int LEN_W      = 5,
  parameter int STOP_TICKS = 3000
) (
  input logic             clk,
  input logic             rst,
  input logic             rise,
  input logic [CNT_W-1:0] iv_cnt,
  input logic             expired,
  input logic             active,
  input logic             frame_valid,
  input logic [LEN_W-1:0] frame_len
);
  // R1: the counter restarts on each detected rise
  p_cnt_restart_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> (iv_cnt == CNT_W'(1)));

  // R5: no strobe unless a frame was open
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !frame_valid);

  // R6: silence past the window closes an open frame
  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    (active && !rise && expired) |=> frame_valid);

  // R7: a reported frame always holds at least one bit
  p_len_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (frame_len != '0));

  // R9: one-cycle strobe, and the frame is closed when it fires
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
  p_closed_r9: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> !active);

  // R10: the counter holds once it reaches its limit
  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (iv_cnt == CNT_W'(STOP_TICKS) && !rise) |=> (iv_cnt == CNT_W'(STOP_TICKS)));
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    iv_cnt <= CNT_W'(STOP_TICKS));
endmodule

bind pause_frame_decoder pfd_checker #(
  .CNT_W      (CNT_W),
  .LEN_W      (LEN_W),
  .STOP_TICKS (STOP_TICKS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rise        (rise),
  .iv_cnt      (iv_cnt),
  .expired     (expired),
  .active      (active),
  .frame_valid (frame_valid),
  .frame_len   (frame_len)
);

// File: tb/pause_frame_decoder_test.sv
`timescale 1ns/1ps
module pause_frame_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        level_in = 1'b1;
  logic        frame_valid;
  logic [30:0] frame_data;
  logic [4:0]  frame_len;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pause_frame_decoder uut (
    .clk         (clk),
    .rst         (rst),
    .level_in    (level_in),
    .frame_valid (frame_valid),
    .frame_data  (frame_data),
    .frame_len   (frame_len)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // low pause of 30 cycles, then rise on a negative edge
  task automatic start_rise();
    level_in = 1'b0;
    repeat (30) @(negedge clk);
    level_in = 1'b1;
  endtask

  // next rise exactly n cycles after the previous one
  task automatic send_ivl(input int n);
    repeat (n - 30) @(negedge clk);
    start_rise();
  endtask

  task automatic send_word(input logic [63:0] w, input int n);
    start_rise();
    for (int i = 0; i < n; i++) send_ivl(w[i] ? 150 : 90);
  endtask

  // wait for a strobe; returns cycles from last drive, or 0 when none
  task automatic wait_frame(input int limit, output int cyc,
                            output logic [30:0] d, output logic [4:0] l);
    cyc = 0; d = '0; l = '0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (frame_valid) begin
        cyc = i; d = frame_data; l = frame_len;
        @(negedge clk);
        chk(!frame_valid, "R9 strobe one cycle", frame_valid, 0);
        chk(frame_data == d && frame_len == l, "R9 outputs held", frame_data, d);
        break;
      end
    end
  endtask

  task automatic t_reset();
    chk(frame_valid == 1'b0, "R11 valid after reset", frame_valid, 0);
    chk(frame_data == '0, "R11 data after reset", frame_data, 0);
    chk(frame_len == '0, "R11 len after reset", frame_len, 0);
  endtask

  task automatic t_word(input logic [63:0] w, input int n, input string tag);
    int cyc; logic [30:0] d; logic [4:0] l;
    send_word(w, n);
    wait_frame(400, cyc, d, l);
    chk(cyc == 173, {tag, " R6 timeout delay"}, cyc, 173);
    chk(d == w[30:0], {tag, " R7 data"}, d, w[30:0]);
    chk(l == 5'(n), {tag, " R7 len"}, l, n);
  endtask

  task automatic t_windows();
    int cyc; logic [30:0] d; logic [4:0] l;
    start_rise();
    send_ivl(131); send_ivl(169); send_ivl(71); send_ivl(109);
    wait_frame(400, cyc, d, l);
    chk(l == 5'd4, "R2 R3 boundary len", l, 4);
    chk(d == 31'h3, "R2 R3 boundary data", d, 3);
  endtask

  task automatic t_invalid_end(input int bad, input string tag);
    int cyc; logic [30:0] d; logic [4:0] l;
    start_rise();
    send_ivl(150); send_ivl(90);
    send_ivl(bad);
    wait_frame(400, cyc, d, l);
    chk(cyc == 3, {tag, " R4 close at edge"}, cyc, 3);
    chk(l == 5'd2 && d == 31'h1, {tag, " R4 partial frame"}, d, 1);
    wait_frame(400, cyc, d, l);
    chk(cyc == 0, {tag, " R5 nothing after close"}, cyc, 0);
  endtask

  task automatic t_idle_invalid();
    int cyc; logic [30:0] d; logic [4:0] l;
    start_rise();
    send_ivl(200);
    wait_frame(400, cyc, d, l);
    chk(cyc == 0, "R5 invalid while idle", cyc, 0);
  endtask

  task automatic t_overflow();
    logic [63:0] w = 64'h5_A5C3_96E1;
    int cyc; logic [30:0] d; logic [4:0] l;
    send_word(w, 35);
    wait_frame(400, cyc, d, l);
    chk(l == 5'd31, "R8 len capped", l, 31);
    chk(d == w[30:0], "R8 first bits kept", d, w[30:0]);
  endtask

  task automatic t_saturate();
    int cyc; logic [30:0] d; logic [4:0] l;
    start_rise();
    send_ivl(4246);
    send_ivl(150);
    wait_frame(400, cyc, d, l);
    chk(l == 5'd1 && d == 31'h1, "R10 long gap not aliased", l, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_word(64'h55, 7, "iv7");
    t_word(64'h19, 6, "ack6");
    t_word(64'h5A3, 11, "rd11");
    t_word(64'h6C_3A5B, 23, "wr23");
    t_word(64'h0, 5, "zeros R1 R9");
    t_windows();
    t_invalid_end(130, "hi");
    t_invalid_end(110, "mid");
    t_invalid_end(70, "lo");
    t_idle_invalid();
    t_overflow();
    t_saturate();
    t_word(64'h1, 1, "after R9 restart");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule